// File: doc/BRIEF.md
# Packed 36-bit Word Unpacker

This block takes a stream of 32-bit words in which every group of nine words, called a slice, carries eight 36-bit data words. It buffers one slice, rebuilds the eight 36-bit words and sends them out in order on a valid/ready stream. In each slice, input words 0 to 7 carry the low 32 bits of data words 0 to 7. The ninth input word collects the four upper bits of all eight data words, and data word 0 sits in its top nibble.

A transfer begins with a one-cycle `start` that gives two values: how many leading words of the first slice to skip, and how many data words to deliver. The input length must then be whole slices: enough slices to cover the skipped words plus the delivered words, with `in_last` marking the final input word. If the input ends early or runs past that length, `len_err` is raised. A partial slice is never emitted. A synchronous `clear` abandons a transfer at any point.

Top module: `slice_unpacker`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `len_err` are all low.
- R2: Within a slice, data word k (k = 0..7) equals {bits [31-4k : 28-4k] of input word 8, input word k}. Word 0 takes the top nibble and word 7 the bottom nibble.
- R3: Words leave in ascending index order, and slices leave in the order they arrived. The first output of a transfer is word `start_skip` of the first slice. Every later slice starts at word 0.
- R4: A transfer delivers exactly N words, where N is `start_words` clamped to MAX_WORDS (224). `out_last` is high on the N-th word only. A `start` with N = 0 does not begin a transfer, so `in_ready` stays low.
- R5: The expected input length is E = ceil((skip + N) / 8) * 9 words. When `in_last` arrives on word E, all N words are delivered and `len_err` stays low.
- R6: If `in_last` arrives before word E, `len_err` goes high. Every complete slice received so far is still emitted, up to N words. Words of a partial slice are dropped.
- R7: If word E arrives without `in_last`, `len_err` goes high and all N words are still delivered. Any further input words are accepted and dropped, up to and including the one marked `in_last`.
- R8: `in_ready` is low while a slice is being emitted. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R9: A `start` that arrives while a transfer is in progress is ignored.
- R10: `clear` returns the block to idle in the next cycle. It aborts any transfer, drops buffered words and lowers `len_err`.
- R11: `len_err` stays high until the next accepted `start` or a `clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous abort and return to idle |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_skip | input | 3 | Words to skip in the first slice |
| start_words | input | 10 | Number of data words to deliver |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | 32 | Packed input word |
| in_last | input | 1 | Marks the final input word of the transfer |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 36 | Rebuilt data word |
| out_last | output | 1 | Marks the final delivered word |
| len_err | output | 1 | Input length did not match the expected length |

## Verification
Two events can fall in the same cycle: the final delivered word, and the end of a slice whose input was already found short or overlong. Which one decides the next state matters, because it selects between idle, draining and refilling. The bench provokes this in two ways. It cuts the input off at a slice boundary just before the slice holding the N-th word. It also overruns the input so that the N-th word is in the last expected slice, with random gaps on both handshakes. In each case it judges the result by the exact output word count, by where `out_last` falls, by the state of `len_err`, and by whether the next transfer runs cleanly.

// File: rtl/unpk_pkg.sv
// Package: shared types for the packed 36-bit word unpacker.
// Assumes: nothing beyond SystemVerilog enums.
package unpk_pkg;

    // Transfer sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a start
        ST_FILL  = 2'd1,   // collecting the nine words of a slice
        ST_EMIT  = 2'd2,   // presenting rebuilt words downstream
        ST_DRAIN = 2'd3    // discarding overrun input up to in_last
    } unpk_state_e;

endpackage

// File: rtl/unpk_req_calc.sv
// Module: unpk_req_calc
// Turns a transfer request into the clamped word count and the number of
// whole slices the input must carry.
// Assumes: REQ_W is wide enough to hold MAX_WORDS; purely combinational.
module unpk_req_calc #(
    parameter int SLICE_WORDS = 8,
    parameter int MAX_WORDS   = 224,
    parameter int REQ_W       = 10,
    parameter int IDX_W       = $clog2(SLICE_WORDS),
    parameter int CNT_W       = $clog2(MAX_WORDS + 1),
    parameter int SLC_W       = $clog2((MAX_WORDS + 2 * SLICE_WORDS - 1) / SLICE_WORDS + 1)
) (
    input  logic [REQ_W-1:0] req_words,
    input  logic [IDX_W-1:0] req_skip,
    output logic [CNT_W-1:0] words_eff,
    output logic [SLC_W-1:0] slices_exp,
    output logic             req_zero
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] span_up;

    // Clamp the requested count to the chunk limit
    always_comb begin
        if (req_words > REQ_W'(MAX_WORDS)) begin
            words_eff = CNT_W'(MAX_WORDS);
        end else begin
            words_eff = CNT_W'(req_words);
        end
    end

    // Round skip plus count up to whole slices
    always_comb begin
        span       = {1'b0, words_eff} + SUM_W'(req_skip);
        span_up    = span + SUM_W'(SLICE_WORDS - 1);
        slices_exp = SLC_W'(span_up / SUM_W'(SLICE_WORDS));
        req_zero   = (req_words == '0);
    end

endmodule

// File: rtl/unpk_slice_buf.sv
// Module: unpk_slice_buf
// Holds one slice: SLICE_WORDS low words plus the shared nibble word, and
// presents the rebuilt wide word chosen by rd_idx.
// Assumes: LOW_W == SLICE_WORDS * NIB_W; the nibble for word k sits at
// descending position (word 0 in the top nibble). Data registers carry no
// reset; the sequencer never presents them before a full slice is written.
module unpk_slice_buf #(
    parameter int LOW_W       = 32,
    parameter int NIB_W       = 4,
    parameter int SLICE_WORDS = 8,
    parameter int DATA_W      = LOW_W + NIB_W,
    parameter int IDX_W       = $clog2(SLICE_WORDS),
    parameter int POS_W       = $clog2(SLICE_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [LOW_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [SLICE_WORDS-1:0][LOW_W-1:0]  low_q;
    logic [LOW_W-1:0]                   nib_q;
    logic [SLICE_WORDS-1:0][DATA_W-1:0] cand;

    // Store each arriving word at its slice position
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < SLICE_WORDS; k++) begin
                if (wr_pos == POS_W'(k)) begin
                    low_q[k] <= wr_data;
                end
            end
            if (wr_pos == POS_W'(SLICE_WORDS)) begin
                nib_q <= wr_data;
            end
        end
    end

    // Rebuild every candidate word from its low part and its nibble
    for (genvar k = 0; k < SLICE_WORDS; k++) begin : g_word
        assign cand[k] = {nib_q[(SLICE_WORDS - 1 - k) * NIB_W +: NIB_W], low_q[k]};
    end

    // Select the word currently being emitted
    assign rd_data = cand[rd_idx];

    AST_WR_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_pos <= POS_W'(SLICE_WORDS))); // R2

endmodule

// File: rtl/unpk_seq.sv
// Module: unpk_seq
// Transfer sequencer: accepts a start when idle, steps through the slice
// positions of the input, checks the input length against the expected
// slice count, walks the emit index and the remaining word count, and drains
// overrun input.
// Assumes: a single slice buffer, so input and output never run at once.
module unpk_seq
    import unpk_pkg::*;
#(
    parameter int SLICE_WORDS = 8,
    parameter int MAX_WORDS   = 224,
    parameter int IDX_W       = $clog2(SLICE_WORDS),
    parameter int POS_W       = $clog2(SLICE_WORDS + 1),
    parameter int CNT_W       = $clog2(MAX_WORDS + 1),
    parameter int SLC_W       = $clog2((MAX_WORDS + 2 * SLICE_WORDS - 1) / SLICE_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic [IDX_W-1:0] start_skip,
    input  logic [CNT_W-1:0] words_eff,
    input  logic [SLC_W-1:0] slices_exp,
    input  logic             req_zero,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_pos,
    output logic [IDX_W-1:0] rd_idx,
    output logic             len_err
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLICE_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLICE_WORDS - 1);

    unpk_state_e      state_q;
    logic [POS_W-1:0] pos_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] rem_q;
    logic [SLC_W-1:0] slc_left_q;
    logic             end_after_q;
    logic             drain_after_q;
    logic             err_q;

    logic in_fire;
    logic out_fire;
    logic start_ok;
    logic final_slice;

    // Handshake and port decode from the current state
    always_comb begin
        in_ready    = (state_q == ST_FILL) || (state_q == ST_DRAIN);
        out_valid   = (state_q == ST_EMIT);
        out_last    = out_valid && (rem_q == CNT_W'(1));
        in_fire     = in_valid && in_ready;
        out_fire    = out_valid && out_ready;
        wr_en       = in_fire && (state_q == ST_FILL);
        wr_pos      = pos_q;
        rd_idx      = idx_q;
        len_err     = err_q;
        start_ok    = start && (state_q == ST_IDLE) && !req_zero;
        final_slice = (slc_left_q == SLC_W'(1));
    end

    // Sequencer state, counters and the sticky length error
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q       <= ST_IDLE;
            pos_q         <= '0;
            idx_q         <= '0;
            rem_q         <= '0;
            slc_left_q    <= '0;
            end_after_q   <= 1'b0;
            drain_after_q <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q       <= ST_FILL;
                        pos_q         <= '0;
                        idx_q         <= start_skip;
                        rem_q         <= words_eff;
                        slc_left_q    <= slices_exp;
                        end_after_q   <= 1'b0;
                        drain_after_q <= 1'b0;
                        err_q         <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (in_fire) begin
                        if (pos_q == LAST_POS) begin
                            // Slice complete: judge the length, then emit
                            state_q       <= ST_EMIT;
                            slc_left_q    <= slc_left_q - SLC_W'(1);
                            end_after_q   <= in_last;
                            drain_after_q <= !in_last && final_slice;
                            if (in_last != final_slice) begin
                                err_q <= 1'b1;
                            end
                        end else if (in_last) begin
                            // Input stopped inside a slice: drop it
                            state_q <= ST_IDLE;
                            err_q   <= 1'b1;
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_fire) begin
                        rem_q <= rem_q - CNT_W'(1);
                        if (rem_q == CNT_W'(1)) begin
                            state_q <= drain_after_q ? ST_DRAIN : ST_IDLE;
                        end else if (idx_q == LAST_IDX) begin
                            idx_q   <= '0;
                            pos_q   <= '0;
                            state_q <= end_after_q ? ST_IDLE : ST_FILL;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (in_fire && in_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!out_valid && !in_ready && !len_err)); // R10

    AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && !clear) |=> !len_err); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !clear && !start_ok) |=> len_err); // R11

    AST_LAST_ENDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && !clear) |=> !out_valid); // R4

    AST_EMIT_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R8

endmodule

// File: rtl/slice_unpacker.sv
// Module: slice_unpacker (top)
// Unpacks nine-word slices of 32-bit input into eight 36-bit output words
// on valid/ready streams, with a start offset, a word limit and a length
// check on the input.
// Assumes: one slice of buffering; input stalls while a slice is emitted.
module slice_unpacker #(
    parameter int LOW_W       = 32,
    parameter int NIB_W       = 4,
    parameter int SLICE_WORDS = 8,
    parameter int MAX_WORDS   = 224,
    parameter int REQ_W       = 10,
    parameter int DATA_W      = LOW_W + NIB_W,
    parameter int IDX_W       = $clog2(SLICE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_skip,
    input  logic [REQ_W-1:0]  start_words,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LOW_W-1:0]  in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              len_err
);

    localparam int POS_W = $clog2(SLICE_WORDS + 1);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam int SLC_W = $clog2((MAX_WORDS + 2 * SLICE_WORDS - 1) / SLICE_WORDS + 1);

    logic [CNT_W-1:0] words_eff;
    logic [SLC_W-1:0] slices_exp;
    logic             req_zero;
    logic             wr_en;
    logic [POS_W-1:0] wr_pos;
    logic [IDX_W-1:0] rd_idx;

    unpk_req_calc #(
        .SLICE_WORDS(SLICE_WORDS),
        .MAX_WORDS  (MAX_WORDS),
        .REQ_W      (REQ_W),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W),
        .SLC_W      (SLC_W)
    ) u_calc (
        .req_words (start_words),
        .req_skip  (start_skip),
        .words_eff (words_eff),
        .slices_exp(slices_exp),
        .req_zero  (req_zero)
    );

    unpk_seq #(
        .SLICE_WORDS(SLICE_WORDS),
        .MAX_WORDS  (MAX_WORDS),
        .IDX_W      (IDX_W),
        .POS_W      (POS_W),
        .CNT_W      (CNT_W),
        .SLC_W      (SLC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .start     (start),
        .start_skip(start_skip),
        .words_eff (words_eff),
        .slices_exp(slices_exp),
        .req_zero  (req_zero),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos),
        .rd_idx    (rd_idx),
        .len_err   (len_err)
    );

    unpk_slice_buf #(
        .LOW_W      (LOW_W),
        .NIB_W      (NIB_W),
        .SLICE_WORDS(SLICE_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .POS_W      (POS_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .wr_data(in_data),
        .rd_idx (rd_idx),
        .rd_data(out_data)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clear) |=>
            (out_valid && $stable(out_data) && $stable(out_last))); // R8

endmodule

// File: tb/slice_unpacker_bench.sv
// Bench: random and directed transfers checked against a bench-side model
// of slice packing, length rules and handshakes.
module slice_unpacker_bench;

    localparam int MAXW = 224;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  start_skip = '0;
    logic [9:0]  start_words = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [35:0] out_data;
    logic        out_last;
    logic        len_err;

    int checks = 0;
    int errors = 0;

    logic [35:0] src   [0:263];
    logic [35:0] exp_w [0:263];
    int          exp_n;
    bit          exp_full;
    bit          drv_done;

    always #10 clk = ~clk;

    slice_unpacker u_slice_unpacker (
        .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
        .start_skip(start_skip), .start_words(start_words),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .len_err(len_err)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Packed input word j per the slice layout
    function automatic logic [31:0] in_word(input int j);
        int s = j / 9;
        int p = j % 9;
        logic [31:0] nib = '0;
        if (p < 8) return src[s * 8 + p][31:0];
        for (int k = 0; k < 8; k++) nib[28 - 4 * k +: 4] = src[s * 8 + k][35:32];
        return nib;
    endfunction

    function automatic int eff_words(input int n);
        return (n > MAXW) ? MAXW : n;
    endfunction

    function automatic int exp_len(input int skip, input int n);
        return ((skip + eff_words(n) + 7) / 8) * 9;
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 264; i++) src[i] = {4'($urandom % 16), 32'($urandom)};
    endtask

    task automatic pulse_start(input int skip, input int n);
        @(negedge clk);
        start = 1'b1; start_skip = 3'(skip); start_words = 10'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_xfer(input int skip, input int n, input int in_len,
                            input bit poke, input string tag);
        int e = exp_len(skip, n);
        int eff = eff_words(n);
        int slices = ((in_len < e) ? in_len : e) / 9;
        int got = 0;
        bit stall = 1'b0;
        logic [35:0] held = '0;
        exp_n = 0;
        for (int s = 0; s < slices; s++)
            for (int k = (s == 0) ? skip : 0; k < 8; k++)
                if (exp_n < eff) begin exp_w[exp_n] = src[s * 8 + k]; exp_n++; end
        exp_full = (exp_n == eff);
        drv_done = 1'b0;
        pulse_start(skip, n);
        fork
            begin : driver
                int i = 0;
                bit poked = 1'b0;
                while (i < in_len) begin
                    start = 1'b0;
                    if (poke && !poked && i == 2) begin
                        start = 1'b1; start_skip = 3'd3; start_words = 10'd5; poked = 1'b1;
                    end
                    in_valid = ($urandom % 10) < 7;
                    in_data  = in_word(i);
                    in_last  = (i == in_len - 1);
                    if (in_valid && in_ready) i++;
                    @(negedge clk);
                end
                in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
                drv_done = 1'b1;
            end
            begin : collector
                int idle = 0;
                while (!(drv_done && idle >= 60)) begin
                    if (drv_done) idle++;
                    if (stall) begin
                        check(out_valid && out_data == held, {"R8 hold ", tag},
                              64'(out_data), 64'(held));
                    end
                    if (out_valid && in_ready)
                        check(1'b0, {"R8 in_ready during emit ", tag}, 1, 0);
                    out_ready = ($urandom % 10) < 7;
                    stall = out_valid && !out_ready;
                    held = out_data;
                    if (out_valid && out_ready) begin
                        if (got < exp_n)
                            check(out_data == exp_w[got], {"R2/R3 word ", tag},
                                  64'(out_data), 64'(exp_w[got]));
                        check(out_last == (exp_full && got == exp_n - 1),
                              {"R4 last flag ", tag}, 64'(out_last),
                              64'(exp_full && got == exp_n - 1));
                        got++;
                    end
                    @(negedge clk);
                end
                out_ready = 1'b0;
            end
        join
        check(got == exp_n, {"R4/R6 word count ", tag}, 64'(got), 64'(exp_n));
        check(len_err == (in_len != e),
              {(in_len < e) ? "R6" : (in_len > e) ? "R7" : "R5", " len_err ", tag},
              64'(len_err), 64'(in_len != e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !in_ready && !len_err, "R1 reset state",
              {out_valid, in_ready, len_err}, 0);

        // R2 directed nibble order: word k gets nibble k+1
        for (int k = 0; k < 16; k++) src[k] = {4'((k % 8) + 1), 32'hA000_0000 + 32'(k)};
        check(in_word(8) == 32'h1234_5678, "R2 bench packing", 64'(in_word(8)), 64'h12345678);
        run_xfer(0, 8, 9, 1'b0, "nibble order");

        // R3 skip corners
        fill_random(); run_xfer(7, 1, 9, 1'b0, "skip7 n1");
        fill_random(); run_xfer(5, 12, 18, 1'b0, "skip5 two slices");

        // R4 clamp: 300 requested, 224 delivered, 252 input words
        fill_random(); run_xfer(0, 300, 252, 1'b0, "clamp");
        fill_random(); run_xfer(7, 224, 261, 1'b0, "max span");

        // R4 zero request does not start
        pulse_start(0, 0);
        @(negedge clk);
        check(!in_ready, "R4 zero start ignored", 64'(in_ready), 0);

        // R9 start while busy
        fill_random(); run_xfer(2, 20, exp_len(2, 20), 1'b1, "R9 busy start");

        // R6 short at slice boundary before final slice, and mid-slice
        fill_random(); run_xfer(0, 20, 18, 1'b0, "short boundary");
        fill_random(); run_xfer(3, 10, 13, 1'b0, "short mid");

        // R11 sticky then R10 clear lowers it
        repeat (5) @(negedge clk);
        check(len_err, "R11 sticky error", 64'(len_err), 1);
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        check(!len_err, "R10 clear drops error", 64'(len_err), 0);

        // R7 overrun with last word in final slice
        fill_random(); run_xfer(1, 15, exp_len(1, 15) + 4, 1'b0, "overrun");

        // R10 abort mid-slice
        pulse_start(0, 8);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_data = 32'hDEAD_0000 + 32'(i); @(negedge clk);
        end
        in_valid = 1'b0;
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        check(!in_ready && !out_valid && !len_err, "R10 clear to idle",
              {in_ready, out_valid, len_err}, 0);
        fill_random(); run_xfer(0, 8, 9, 1'b0, "after clear");

        // Random mix
        for (int t = 0; t < 20; t++) begin
            int skip = $urandom % 8;
            int n = 1 + $urandom % 40;
            int e = exp_len(skip, n);
            int m = $urandom % 10;
            int len = (m < 7) ? e : (m < 9 && e > 1) ? 1 + $urandom % (e - 1)
                                                   : e + 1 + $urandom % 5;
            fill_random();
            run_xfer(skip, n, len, 1'b0, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule